// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the command interpreter that sits on the device side of a byte-wide parallel NOR flash with a 17-bit address bus. Each write cycle on the bus arrives as a one-clock strobe carrying an address and a data byte. The decoder checks these writes against keyed unlock sequences built from two fixed magic addresses. Each accepted write moves it one step along a sequence. When a sequence completes, the decoder issues a single-clock command pulse to the embedded program/erase engine. The pulse carries the operation code and the captured address and data.

It also keeps two boot-region lock flags. It refuses program and erase requests that would touch a locked region. It owns an identification read path: while identification mode is active, reads return fixed code bytes or the lock flags. The engine reports back through a `busy` level. Writes that arrive while `busy` is high do not reach the decoder.

Top module: `nfc_cmd_decoder`

## Requirements
- R1: After reset, `cmd_valid` is 0, `id_active` is 0, `rd_data` is 0x00 and both boot locks are clear.
- R2: The writes 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0xA0 followed by any address A with data D raise `cmd_valid` for exactly one clock. The pulse comes one clock after the final write and carries `cmd_op`=1 (program), `cmd_addr`=A and `cmd_data`=D.
- R3: The writes 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x80, 0x05555/0xAA, 0x02AAA/0x55 followed by data 0x50 at any address A issue `cmd_op`=2 (page erase). `cmd_addr` is A with bits 11..0 cleared, so bits 16..12 select one of 32 pages of 4 KB.
- R4: The same five-write prefix followed by 0x05555/0x10 issues `cmd_op`=3 (chip erase) with `cmd_addr`=0.
- R5: A write that does not match the next expected step sends the decoder back to idle without a command. A later complete sequence is still accepted.
- R6: 0x05555/0xAA, 0x02AAA/0x55, 0x05555/0x90 enters identification mode. In that mode, one clock after `rd_addr` is presented, `rd_data` returns 0xDA when the low address byte is 0x00 and 0x31 when it is 0x01. The same prefix with 0xF0 leaves the mode. Outside the mode, `rd_data` is 0x00.
- R7: The prefix with 0x70, followed by a write to 0x1FFFF, locks the top 8 KB region (address bits 16..13 all ones). Followed instead by a write to 0x00000, it locks the bottom 8 KB region (bits 16..13 all zero). Any other final address locks nothing. In identification mode, bit 1 of `rd_data` at 0x00002 shows the bottom lock and at 0x1FFF2 shows the top lock; all other bits of those reads are 0.
- R8: A program or page erase whose address lies in a locked region, and a chip erase while either lock is set, produce no `cmd_valid`.
- R9: A write strobe while `busy` is 1 neither advances nor resets the sequence, and produces no command.
- R10: `id_active` is 1 exactly while identification mode is on, starting one clock after the entry write and ending one clock after the exit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-clock bus write strobe |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Embedded operation in progress |
| rd_addr | input | 17 | Read address for the identification path |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_op | output | 2 | 1 program, 2 page erase, 3 chip erase |
| cmd_addr | output | 17 | Command address (page base for page erase) |
| cmd_data | output | 8 | Final write data of the sequence |
| id_active | output | 1 | Identification mode on |
| rd_data | output | 8 | Identification read data |

## Verification
A command is due exactly one clock after the strobe of its final write, and it must be gone the clock after that. The bench therefore drives each write on a falling edge, then checks the command outputs at the next falling edge and again one clock later. Identification reads and `id_active` are also one register deep: each is sampled on the falling edge that follows the rising edge at which the address or mode write was taken. Random runs of program, page-erase and junk writes are compared with bench functions that apply the lock regions.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_PAGE = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  localparam logic [31:0] KEY_ADDR_A = 32'h0000_5555;
  localparam logic [31:0] KEY_ADDR_B = 32'h0000_2AAA;

  localparam logic [7:0] KEY_BYTE_A = 8'hAA;
  localparam logic [7:0] KEY_BYTE_B = 8'h55;
  localparam logic [7:0] SEL_PROG   = 8'hA0;
  localparam logic [7:0] SEL_ERASE  = 8'h80;
  localparam logic [7:0] SEL_IDIN   = 8'h90;
  localparam logic [7:0] SEL_IDOUT  = 8'hF0;
  localparam logic [7:0] SEL_LOCK   = 8'h70;
  localparam logic [7:0] FIN_PAGE   = 8'h50;
  localparam logic [7:0] FIN_CHIP   = 8'h10;
endpackage

// File: rtl/nfc_seq_fsm.sv
module nfc_seq_fsm
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit_prog,
  output logic              hit_page,
  output logic              hit_chip,
  output logic              hit_lock,
  output logic              hit_id_in,
  output logic              hit_id_out
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

  typedef enum logic [2:0] {
    S_IDLE, S_K1, S_K2, S_PRG, S_E1, S_E2, S_E3, S_LCK
  } seq_e;

  seq_e st, nxt;
  logic on_a, on_b;

  assign on_a = (wr_addr == ADR_A);
  assign on_b = (wr_addr == ADR_B);

  always_comb begin
    nxt        = st;
    hit_prog   = 1'b0;
    hit_page   = 1'b0;
    hit_chip   = 1'b0;
    hit_lock   = 1'b0;
    hit_id_in  = 1'b0;
    hit_id_out = 1'b0;
    if (wr_en) begin
      nxt = S_IDLE;
      case (st)
        S_IDLE: if (on_a && wr_data == DATA_W'(KEY_BYTE_A)) nxt = S_K1;
        S_K1:   if (on_b && wr_data == DATA_W'(KEY_BYTE_B)) nxt = S_K2;
        S_K2: begin
          if (on_a) begin
            if (wr_data == DATA_W'(SEL_PROG))  nxt = S_PRG;
            if (wr_data == DATA_W'(SEL_ERASE)) nxt = S_E1;
            if (wr_data == DATA_W'(SEL_LOCK))  nxt = S_LCK;
            hit_id_in  = (wr_data == DATA_W'(SEL_IDIN));
            hit_id_out = (wr_data == DATA_W'(SEL_IDOUT));
          end
        end
        S_PRG:  hit_prog = 1'b1;
        S_E1:   if (on_a && wr_data == DATA_W'(KEY_BYTE_A)) nxt = S_E2;
        S_E2:   if (on_b && wr_data == DATA_W'(KEY_BYTE_B)) nxt = S_E3;
        S_E3: begin
          hit_page = (wr_data == DATA_W'(FIN_PAGE));
          hit_chip = on_a && (wr_data == DATA_W'(FIN_CHIP));
        end
        S_LCK:  hit_lock = 1'b1;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  // R5
  idle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && st == S_IDLE) |=> (st == S_IDLE || st == S_K1));

  // R2
  prog_origin_chk: assert property (@(posedge clk) disable iff (rst)
    hit_prog |=> (st == S_IDLE));
endmodule

// File: rtl/nfc_boot_lock.sv
module nfc_boot_lock #(
  parameter int ADDR_W = 17,
  parameter int BOOT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_req,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              lock_top,
  output logic              lock_bot,
  output logic              region_ok,
  output logic              chip_ok
);
  localparam int REG_W = ADDR_W - BOOT_W;

  logic [REG_W-1:0] region;
  logic in_top, in_bot;

  assign region    = wr_addr[ADDR_W-1:BOOT_W];
  assign in_top    = (region == {REG_W{1'b1}});
  assign in_bot    = (region == '0);
  assign region_ok = !(lock_top && in_top) && !(lock_bot && in_bot);
  assign chip_ok   = !lock_top && !lock_bot;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_top <= 1'b0;
      lock_bot <= 1'b0;
    end else if (set_req) begin
      if (wr_addr == {ADDR_W{1'b1}}) lock_top <= 1'b1;
      if (wr_addr == '0)             lock_bot <= 1'b1;
    end
  end

  // R7
  top_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock_top |=> lock_top);

  // R7
  bot_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock_bot |=> lock_bot);
endmodule

// File: rtl/nfc_id_mux.sv
module nfc_id_mux #(
  parameter int          ADDR_W   = 17,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'hDA,
  parameter logic [7:0]  DEV_CODE = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_in,
  input  logic              id_out,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              lock_top,
  input  logic              lock_bot,
  output logic              id_active,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] BOT_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] TOP_STAT = {ADDR_W{1'b1}} - ADDR_W'(13);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (id_active) begin
      if (rd_addr == BOT_STAT)           sel = DATA_W'({lock_bot, 1'b0});
      else if (rd_addr == TOP_STAT)      sel = DATA_W'({lock_top, 1'b0});
      else if (rd_addr[7:0] == 8'h00)    sel = DATA_W'(MFR_CODE);
      else if (rd_addr[7:0] == 8'h01)    sel = DATA_W'(DEV_CODE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      id_active <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (id_in)       id_active <= 1'b1;
      else if (id_out) id_active <= 1'b0;
      rd_data <= sel;
    end
  end

  // R6
  quiet_outside_chk: assert property (@(posedge clk) disable iff (rst)
    !id_active |=> (rd_data == '0));

  // R10
  id_enter_chk: assert property (@(posedge clk) disable iff (rst)
    id_in |=> id_active);
endmodule

// File: rtl/nfc_cmd_decoder.sv
module nfc_cmd_decoder
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 12,
  parameter int BOOT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_active,
  output logic [DATA_W-1:0] rd_data
);
  logic wr_en;
  logic hit_prog, hit_page, hit_chip, hit_lock, hit_id_in, hit_id_out;
  logic lock_top, lock_bot, region_ok, chip_ok;
  logic go_prog, go_page, go_chip;

  assign wr_en = wr_stb && !busy;

  nfc_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hit_prog(hit_prog), .hit_page(hit_page), .hit_chip(hit_chip),
    .hit_lock(hit_lock), .hit_id_in(hit_id_in), .hit_id_out(hit_id_out)
  );

  nfc_boot_lock #(.ADDR_W(ADDR_W), .BOOT_W(BOOT_W)) u_lock (
    .clk(clk), .rst(rst), .set_req(hit_lock), .wr_addr(wr_addr),
    .lock_top(lock_top), .lock_bot(lock_bot),
    .region_ok(region_ok), .chip_ok(chip_ok)
  );

  nfc_id_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_idm (
    .clk(clk), .rst(rst), .id_in(hit_id_in), .id_out(hit_id_out),
    .rd_addr(rd_addr), .lock_top(lock_top), .lock_bot(lock_bot),
    .id_active(id_active), .rd_data(rd_data)
  );

  assign go_prog = hit_prog && region_ok;
  assign go_page = hit_page && region_ok;
  assign go_chip = hit_chip && chip_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= go_prog || go_page || go_chip;
      if (go_prog || go_page || go_chip) begin
        cmd_data <= wr_data;
        if (go_prog) begin
          cmd_op   <= OP_PROG;
          cmd_addr <= wr_addr;
        end else if (go_page) begin
          cmd_op   <= OP_PAGE;
          cmd_addr <= {wr_addr[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}};
        end else begin
          cmd_op   <= OP_CHIP;
          cmd_addr <= '0;
        end
      end
    end
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && busy) |=> !cmd_valid);

  // R3
  page_base_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PAGE) |-> (cmd_addr[PAGE_W-1:0] == '0));

  // R8
  locked_prog_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op != OP_CHIP) |->
      !(lock_top && cmd_addr[ADDR_W-1:BOOT_W] == {(ADDR_W-BOOT_W){1'b1}}) &&
      !(lock_bot && cmd_addr[ADDR_W-1:BOOT_W] == '0));
endmodule

// File: tb/nfc_cmd_decoder_bench.sv
`timescale 1ns/1ps
module nfc_cmd_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [16:0] rd_addr = '0;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [16:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        id_active;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit lk_top = 0;
  bit lk_bot = 0;

  always #5 clk = ~clk;

  nfc_cmd_decoder u_nfc_cmd_decoder (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .id_active(id_active), .rd_data(rd_data)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit region_free(logic [16:0] a);
    return !(lk_top && a[16:13] == 4'hF) && !(lk_bot && a[16:13] == 4'h0);
  endfunction

  task automatic wr(logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic prefix(logic [7:0] sel);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, sel);
  endtask

  task automatic prog(logic [16:0] a, logic [7:0] d);
    prefix(8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    prefix(8'h80); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
  endtask

  task automatic rd(logic [16:0] a);
    @(negedge clk); rd_addr = a;
    @(negedge clk);
  endtask

  task automatic expect_cmd(string req, bit v, logic [1:0] op, logic [16:0] a, logic [7:0] d);
    chk(req, "cmd_valid", 32'(cmd_valid), 32'(v));
    if (v) begin
      chk(req, "cmd_op", 32'(cmd_op), 32'(op));
      chk(req, "cmd_addr", 32'(cmd_addr), 32'(a));
      if (op == 2'd1) chk(req, "cmd_data", 32'(cmd_data), 32'(d));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "cmd_valid", 32'(cmd_valid), 0);
    chk("R1", "id_active", 32'(id_active), 0);
    chk("R1", "rd_data", 32'(rd_data), 0);

    // R2 program
    prog(17'h0ABCD, 8'h5A);
    expect_cmd("R2", 1, 2'd1, 17'h0ABCD, 8'h5A);
    @(negedge clk);
    chk("R2", "pulse width", 32'(cmd_valid), 0);

    // R3 page erase
    erase_pre(); wr(17'h0A123, 8'h50);
    expect_cmd("R3", 1, 2'd2, 17'h0A000, 8'h50);

    // R4 chip erase
    erase_pre(); wr(17'h05555, 8'h10);
    expect_cmd("R4", 1, 2'd3, 17'h00000, 8'h10);

    // R5 broken sequences
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h56); wr(17'h05555, 8'hA0); wr(17'h00100, 8'h77);
    expect_cmd("R5", 0, 0, 0, 0);
    erase_pre(); wr(17'h05555, 8'h11);
    expect_cmd("R5", 0, 0, 0, 0);
    prog(17'h00100, 8'h77);
    expect_cmd("R5", 1, 2'd1, 17'h00100, 8'h77);

    // R6 / R10 identification
    prefix(8'h90);
    chk("R10", "id_active", 32'(id_active), 1);
    rd(17'h00000); chk("R6", "mfr code", 32'(rd_data), 32'h DA);
    rd(17'h12300); chk("R6", "mfr code alias", 32'(rd_data), 32'hDA);
    rd(17'h00001); chk("R6", "dev code", 32'(rd_data), 32'h31);
    rd(17'h00002); chk("R1", "bottom lock clear", 32'(rd_data), 0);
    rd(17'h1FFF2); chk("R1", "top lock clear", 32'(rd_data), 0);
    prefix(8'hF0);
    chk("R10", "id_active exit", 32'(id_active), 0);
    rd(17'h00000); chk("R6", "data outside mode", 32'(rd_data), 0);

    // R7 locks
    prefix(8'h90);
    prefix(8'h70); wr(17'h01234, 8'h00);
    rd(17'h1FFF2); chk("R7", "no lock top", 32'(rd_data), 0);
    rd(17'h00002); chk("R7", "no lock bot", 32'(rd_data), 0);
    prefix(8'h70); wr(17'h1FFFF, 8'h00); lk_top = 1;
    rd(17'h1FFF2); chk("R7", "top locked", 32'(rd_data), 32'h02);
    rd(17'h00002); chk("R7", "bot still clear", 32'(rd_data), 0);
    prefix(8'h70); wr(17'h00000, 8'h00); lk_bot = 1;
    rd(17'h00002); chk("R7", "bot locked", 32'(rd_data), 32'h02);

    // R8 locked targets
    prog(17'h1E000, 8'h11); expect_cmd("R8", 0, 0, 0, 0);
    prog(17'h1DFFF, 8'h12); expect_cmd("R8", 1, 2'd1, 17'h1DFFF, 8'h12);
    erase_pre(); wr(17'h1F800, 8'h50); expect_cmd("R8", 0, 0, 0, 0);
    prog(17'h01FFF, 8'h13); expect_cmd("R8", 0, 0, 0, 0);
    prog(17'h02000, 8'h14); expect_cmd("R8", 1, 2'd1, 17'h02000, 8'h14);
    erase_pre(); wr(17'h05555, 8'h10); expect_cmd("R8", 0, 0, 0, 0);

    // R9 busy
    busy = 1'b1;
    prog(17'h04000, 8'h21); expect_cmd("R9", 0, 0, 0, 0);
    busy = 1'b0;
    wr(17'h05555, 8'hAA);
    busy = 1'b1; wr(17'h01234, 8'h00); busy = 1'b0;
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h04444, 8'h22);
    expect_cmd("R9", 1, 2'd1, 17'h04444, 8'h22);

    // random mix against bench model
    for (int i = 0; i < 60; i++) begin
      logic [16:0] a;
      logic [7:0]  d;
      int kind;
      a = 17'($urandom); d = 8'($urandom); kind = int'($urandom % 3);
      if (kind == 0) begin
        if (d == 8'hAA) d = 8'h00;
        wr(a, d); expect_cmd("R5", 0, 0, 0, 0);
      end else if (kind == 1) begin
        prog(a, d); expect_cmd("R8", region_free(a), 2'd1, a, d);
      end else begin
        erase_pre(); wr(a, 8'h50);
        expect_cmd("R3", region_free(a), 2'd2, {a[16:12], 12'h000}, 8'h50);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule